// File: doc/BRIEF.md
# Floppy Drive Select and Data Rate Control

This block holds the small set of control registers that a PC-style floppy disk controller uses to pick a drive and a transfer rate. Software writes them over a simple 8-bit register bus: one register holds the drive number and four motor-enable bits, two registers each hold a 2-bit rate code, and an option register holds an encoded four-drive mode bit, a swap bit for logical drives 0 and 1, and a 2 Mbps mode bit.

From these registers the block drives two active-low drive-select pins, two rate-indication pins, a density-select pin whose polarity follows a strap input, and an active-low head direction pin formed from the seek state. The effective rate code comes from whichever of the two rate registers software wrote most recently. Every output comes from a register, so decode glitches never reach the pins. A register write is sampled on one rising edge, and the pins change on the next rising edge.

Top module: `fdc_drvctl`

## Requirements
- R1: After reset, drv_sel_n is 2'b11, rate_ind is 2'b00, head_dir_n is 1, dens_out is 1, and every register reads back 0.
- R2: In normal mode, drive register (address 0) bits 1:0 give the logical drive and bit 4+n is the motor enable of drive n. Drive 0 with its motor bit set pulls drv_sel_n[0] low. Drive 1 with its motor bit set pulls drv_sel_n[1] low. Any other case leaves both pins high. The pins change on the second rising edge after the write is sampled.
- R3: With option bit 1 (swap) set in normal mode, logical drive 0 selects pin 1 and logical drive 1 selects pin 0. The gating still uses the logical drive's own motor bit.
- R4: With option bit 0 (encoded) set, drv_sel_n carries the inverted 2-bit physical drive number (after any swap) while the selected logical drive's motor bit is set, and 2'b11 otherwise.
- R5: A write to address 1 or address 2 stores bits 1:0 as a rate code, and rate_ind then mirrors the code of whichever of the two was written last.
- R6: Until a rate register is written, the address 1 path is used. A write to one rate register leaves the stored value of the other unchanged.
- R7: Rate codes 00 (500 kbps) and 11 (1 Mbps), and any rate while option bit 2 (2 Mbps mode) is set, are high density. Codes 01 (300 kbps) and 10 (250 kbps) are low density. dens_out equals the high-density flag when ident is 1 and its inverse when ident is 0, one rising edge after ident changes.
- R8: head_dir_n is 0 (step in) only when seek_busy=1, seek_in=1 and xfer_busy=0 were sampled on the previous rising edge. Otherwise it is 1.
- R9: rd_data shows the register picked by rd_addr without a clock. Address 0 returns all 8 bits, addresses 1 and 2 return the rate code in bits 1:0, and address 3 returns {turbo, swap, encoded} in bits 2:0. All other bits read 0.
- R10: With wr_en low, wr_addr and wr_data change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Readback address |
| rd_data | output | DATA_W | Readback data |
| ident | input | 1 | Strap that sets density polarity |
| seek_busy | input | 1 | A seek is in progress |
| seek_in | input | 1 | The seek steps inward |
| xfer_busy | input | 1 | A read or write is in progress |
| drv_sel_n | output | 2 | Active-low drive-select pins |
| rate_ind | output | 2 | Effective rate code |
| dens_out | output | 1 | Density select |
| head_dir_n | output | 1 | Head direction, low for step in |

## Verification
A write drives wr_en from one falling edge to the next. The register updates on the rising edge between them, so readback is checked just after that falling edge. The select, rate and density pins need one more rising edge, so the bench waits one more falling edge before it samples them. Changes to ident or to the seek and transfer inputs need exactly one rising edge. Each check samples at the falling edge right after the edge that makes the result due, never earlier.

// File: rtl/fdc_drvctl_pkg.sv
package fdc_drvctl_pkg;
    localparam int DRV_W  = 8;
    localparam int RATE_W = 2;

    typedef enum logic [1:0] {
        A_DRIVE    = 2'd0,
        A_RATE_CFG = 2'd1,
        A_RATE_SEL = 2'd2,
        A_OPTION   = 2'd3
    } reg_addr_e;

    localparam logic [RATE_W-1:0] RATE_500K = 2'b00;
    localparam logic [RATE_W-1:0] RATE_300K = 2'b01;
    localparam logic [RATE_W-1:0] RATE_250K = 2'b10;
    localparam logic [RATE_W-1:0] RATE_1M   = 2'b11;

    typedef struct packed {
        logic [DRV_W-1:0]  drive;
        logic [RATE_W-1:0] rate_cfg;
        logic [RATE_W-1:0] rate_sel;
        logic              sel_last;
        logic              enc4;
        logic              swap01;
        logic              turbo;
    } regs_t;

    typedef struct packed {
        logic [1:0]        sel_n;
        logic [RATE_W-1:0] rate;
        logic              dens;
        logic              dir_n;
    } outs_t;
endpackage

// File: rtl/fdc_regs.sv
module fdc_regs
    import fdc_drvctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output regs_t             regs_o,
    output logic [DATA_W-1:0] rd_data
);
    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr[1:0]))
                A_DRIVE: st_d.drive = wr_data[DRV_W-1:0];
                A_RATE_CFG: begin
                    st_d.rate_cfg = wr_data[RATE_W-1:0];
                    st_d.sel_last = 1'b0;
                end
                A_RATE_SEL: begin
                    st_d.rate_sel = wr_data[RATE_W-1:0];
                    st_d.sel_last = 1'b1;
                end
                default: begin
                    st_d.enc4   = wr_data[0];
                    st_d.swap01 = wr_data[1];
                    st_d.turbo  = wr_data[2];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr[1:0]))
            A_DRIVE:    rd_data = DATA_W'(st_q.drive);
            A_RATE_CFG: rd_data = DATA_W'(st_q.rate_cfg);
            A_RATE_SEL: rd_data = DATA_W'(st_q.rate_sel);
            default:    rd_data = DATA_W'({st_q.turbo, st_q.swap01, st_q.enc4});
        endcase
    end

    assign regs_o = st_q;
endmodule

// File: rtl/fdc_sel_decode.sv
module fdc_sel_decode
    import fdc_drvctl_pkg::*;
(
    input  logic [DRV_W-1:0] drive,
    input  logic             enc4,
    input  logic             swap01,
    output logic [1:0]       sel_n
);
    logic [1:0] lsel;
    logic [1:0] psel;
    logic       motor_on;

    always_comb begin
        lsel     = drive[1:0];
        motor_on = drive[4 + lsel];
        psel     = (swap01 && !lsel[1]) ? {lsel[1], ~lsel[0]} : lsel;
        sel_n    = 2'b11;
        if (motor_on) begin
            if (enc4)          sel_n = ~psel;
            else if (!psel[1]) sel_n[psel[0]] = 1'b0;
        end
    end
endmodule

// File: rtl/fdc_rate_logic.sv
module fdc_rate_logic
    import fdc_drvctl_pkg::*;
(
    input  logic [RATE_W-1:0] rate_cfg,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sel_last,
    input  logic              turbo,
    input  logic              ident,
    output logic [RATE_W-1:0] rate_eff,
    output logic              dens
);
    logic high;

    always_comb begin
        rate_eff = sel_last ? rate_sel : rate_cfg;
        high     = turbo || (rate_eff == RATE_500K) || (rate_eff == RATE_1M);
        dens     = ident ? high : !high;
    end
endmodule

// File: rtl/fdc_drvctl.sv
module fdc_drvctl
    import fdc_drvctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ident,
    input  logic              seek_busy,
    input  logic              seek_in,
    input  logic              xfer_busy,
    output logic [1:0]        drv_sel_n,
    output logic [1:0]        rate_ind,
    output logic              dens_out,
    output logic              head_dir_n
);
    regs_t             regs;
    logic [1:0]        sel_n_c;
    logic [RATE_W-1:0] rate_eff;
    logic              dens_c;
    logic              enc_mode;
    logic              turbo_mode;
    outs_t             out_d, out_q;

    fdc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .regs_o(regs), .rd_data(rd_data)
    );

    fdc_sel_decode u_sel (
        .drive(regs.drive), .enc4(regs.enc4), .swap01(regs.swap01), .sel_n(sel_n_c)
    );

    fdc_rate_logic u_rate (
        .rate_cfg(regs.rate_cfg), .rate_sel(regs.rate_sel), .sel_last(regs.sel_last),
        .turbo(regs.turbo), .ident(ident), .rate_eff(rate_eff), .dens(dens_c)
    );

    assign enc_mode   = regs.enc4;
    assign turbo_mode = regs.turbo;

    always_comb begin
        out_d.sel_n = sel_n_c;
        out_d.rate  = rate_eff;
        out_d.dens  = dens_c;
        out_d.dir_n = !(seek_busy && seek_in && !xfer_busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{sel_n: 2'b11, rate: RATE_500K, dens: 1'b1, dir_n: 1'b1};
        else        out_q <= out_d;
    end

    assign drv_sel_n  = out_q.sel_n;
    assign rate_ind   = out_q.rate;
    assign dens_out   = out_q.dens;
    assign head_dir_n = out_q.dir_n;
endmodule

// File: rtl/fdc_drvctl_chk.sv
module fdc_drvctl_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              ident,
    input logic              seek_busy,
    input logic              seek_in,
    input logic              xfer_busy,
    input logic [1:0]        drv_sel_n,
    input logic [1:0]        rate_ind,
    input logic              dens_out,
    input logic              head_dir_n,
    input logic              enc_mode,
    input logic              turbo_mode,
    input logic [1:0]        rate_eff
);
    logic [1:0] age;
    logic       rate_wr;
    logic       ok1, ok2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        age <= '0;
        else if (age != 3) age <= age + 2'd1;
    end

    assign rate_wr = wr_en && (wr_addr == ADDR_W'(1) || wr_addr == ADDR_W'(2));
    assign ok1 = (age >= 2'd1);
    assign ok2 = (age >= 2'd2);

    AST_RATE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ok2 && $past(rate_wr, 2) && !$past(rate_wr)) |-> rate_ind == $past(wr_data[1:0], 2)); // R5

    AST_DIR_HELD_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (ok1 && $past(xfer_busy)) |-> head_dir_n); // R8

    AST_DIR_STEP_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (ok1 && $past(seek_busy && seek_in && !xfer_busy)) |-> !head_dir_n); // R8

    AST_NORMAL_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ok1 && $past(!enc_mode)) |-> $countones(~drv_sel_n) <= 1); // R2

    AST_LOW_DENSITY_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (ok1 && $past(!turbo_mode && rate_eff == 2'b01)) |-> dens_out == !$past(ident)); // R7
endmodule

bind fdc_drvctl fdc_drvctl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ident(ident), .seek_busy(seek_busy), .seek_in(seek_in), .xfer_busy(xfer_busy),
    .drv_sel_n(drv_sel_n), .rate_ind(rate_ind), .dens_out(dens_out),
    .head_dir_n(head_dir_n), .enc_mode(enc_mode), .turbo_mode(turbo_mode),
    .rate_eff(rate_eff)
);

// File: tb/fdc_drvctl_bench.sv
module fdc_drvctl_bench;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              ident = 1'b1;
    logic              seek_busy = 1'b0;
    logic              seek_in = 1'b0;
    logic              xfer_busy = 1'b0;
    logic [1:0]        drv_sel_n;
    logic [1:0]        rate_ind;
    logic              dens_out;
    logic              head_dir_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fdc_drvctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fdc_drvctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ident(ident), .seek_busy(seek_busy),
        .seek_in(seek_in), .xfer_busy(xfer_busy), .drv_sel_n(drv_sel_n),
        .rate_ind(rate_ind), .dens_out(dens_out), .head_dir_n(head_dir_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // register updates on the edge inside this task; returns just after the next falling edge
    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // pins are due one rising edge after the register update
    task automatic write_settle(input logic [1:0] a, input logic [7:0] d);
        do_write(a, d);
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 drv_sel_n", {6'b0, drv_sel_n}, 8'h03);
        chk("R1 rate_ind", {6'b0, rate_ind}, 8'h00);
        chk("R1 head_dir_n", {7'b0, head_dir_n}, 8'h01);
        chk("R1 dens_out", {7'b0, dens_out}, 8'h01);
        for (int a = 0; a < 4; a++) begin
            read_reg(a[1:0], v);
            chk("R1 readback", v, 8'h00);
        end
    endtask

    task automatic t_normal;
        write_settle(2'd0, 8'h10); chk("R2 drive0 motor0", {6'b0, drv_sel_n}, 8'h02);
        write_settle(2'd0, 8'h21); chk("R2 drive1 motor1", {6'b0, drv_sel_n}, 8'h01);
        write_settle(2'd0, 8'h11); chk("R2 drive1 wrong motor", {6'b0, drv_sel_n}, 8'h03);
        write_settle(2'd0, 8'h42); chk("R2 drive2 no pin", {6'b0, drv_sel_n}, 8'h03);
        do_write(2'd0, 8'h10);
        chk("R2 not yet at first edge", {6'b0, drv_sel_n}, 8'h03);
        @(negedge clk);
        chk("R2 due at second edge", {6'b0, drv_sel_n}, 8'h02);
    endtask

    task automatic t_swap;
        do_write(2'd3, 8'h02);
        write_settle(2'd0, 8'h10); chk("R3 logical0 on pin1", {6'b0, drv_sel_n}, 8'h01);
        write_settle(2'd0, 8'h21); chk("R3 logical1 on pin0", {6'b0, drv_sel_n}, 8'h02);
        write_settle(2'd0, 8'h20); chk("R3 gated by logical motor", {6'b0, drv_sel_n}, 8'h03);
        write_settle(2'd3, 8'h00);
    endtask

    task automatic t_encoded;
        do_write(2'd3, 8'h01);
        write_settle(2'd0, 8'h42); chk("R4 drive2", {6'b0, drv_sel_n}, 8'h01);
        write_settle(2'd0, 8'h83); chk("R4 drive3", {6'b0, drv_sel_n}, 8'h00);
        write_settle(2'd0, 8'h03); chk("R4 motor off", {6'b0, drv_sel_n}, 8'h03);
        write_settle(2'd0, 8'h21); chk("R4 drive1", {6'b0, drv_sel_n}, 8'h02);
        write_settle(2'd3, 8'h03); chk("R4 swapped drive1 -> 0", {6'b0, drv_sel_n}, 8'h03);
        write_settle(2'd0, 8'h10); chk("R4 swapped drive0 -> 1", {6'b0, drv_sel_n}, 8'h02);
        write_settle(2'd3, 8'h00);
        write_settle(2'd0, 8'h00);
    endtask

    task automatic t_rate;
        logic [7:0] v;
        write_settle(2'd1, 8'h03); chk("R6 default cfg path", {6'b0, rate_ind}, 8'h03);
        write_settle(2'd2, 8'h02); chk("R5 select path last", {6'b0, rate_ind}, 8'h02);
        read_reg(2'd1, v); chk("R6 cfg kept", v, 8'h03);
        write_settle(2'd1, 8'h01); chk("R5 cfg path last", {6'b0, rate_ind}, 8'h01);
        read_reg(2'd2, v); chk("R6 select kept", v, 8'h02);
    endtask

    task automatic t_density;
        ident = 1'b1;
        write_settle(2'd1, 8'h01); chk("R7 300k low ident1", {7'b0, dens_out}, 8'h00);
        write_settle(2'd1, 8'h00); chk("R7 500k high ident1", {7'b0, dens_out}, 8'h01);
        @(negedge clk); ident = 1'b0;
        @(negedge clk); chk("R7 500k ident0", {7'b0, dens_out}, 8'h00);
        write_settle(2'd2, 8'h02); chk("R7 250k ident0", {7'b0, dens_out}, 8'h01);
        ident = 1'b1;
        @(negedge clk); chk("R7 250k ident1", {7'b0, dens_out}, 8'h00);
        write_settle(2'd3, 8'h04); chk("R7 2M mode high", {7'b0, dens_out}, 8'h01);
        write_settle(2'd2, 8'h03); chk("R7 1M high", {7'b0, dens_out}, 8'h01);
        write_settle(2'd3, 8'h00);
    endtask

    task automatic t_dir;
        @(negedge clk); seek_busy = 1'b1; seek_in = 1'b1; xfer_busy = 1'b0;
        @(negedge clk); chk("R8 step in", {7'b0, head_dir_n}, 8'h00);
        seek_in = 1'b0;
        @(negedge clk); chk("R8 step out", {7'b0, head_dir_n}, 8'h01);
        seek_in = 1'b1; xfer_busy = 1'b1;
        @(negedge clk); chk("R8 held in transfer", {7'b0, head_dir_n}, 8'h01);
        seek_busy = 1'b0; xfer_busy = 1'b0;
        @(negedge clk); chk("R8 no seek", {7'b0, head_dir_n}, 8'h01);
        seek_in = 1'b0;
    endtask

    task automatic t_readback;
        logic [7:0] v;
        do_write(2'd0, 8'hA5); read_reg(2'd0, v); chk("R9 drive reg", v, 8'hA5);
        do_write(2'd3, 8'hFE); read_reg(2'd3, v); chk("R9 option reg", v, 8'h06);
        do_write(2'd1, 8'hFE); read_reg(2'd1, v); chk("R9 rate cfg", v, 8'h02);
        do_write(2'd3, 8'h00); do_write(2'd0, 8'h00);
    endtask

    task automatic t_ignore;
        logic [7:0] v;
        write_settle(2'd0, 8'h10);
        @(negedge clk); wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h21;
        @(negedge clk); wr_addr = 2'd1; wr_data = 8'h02;
        @(negedge clk); @(negedge clk);
        chk("R10 select unchanged", {6'b0, drv_sel_n}, 8'h02);
        chk("R10 rate unchanged", {6'b0, rate_ind}, 8'h01);
        read_reg(2'd0, v); chk("R10 drive reg unchanged", v, 8'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_swap();
        t_encoded();
        t_rate();
        t_density();
        t_dir();
        t_readback();
        write_settle(2'd1, 8'h00);
        write_settle(2'd2, 8'h01);
        t_ignore();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule